// File: doc/BRIEF.md
# Multiprocessor Serial Port with Address Filtering

This block is a full-duplex asynchronous serial port for multi-node buses. It sends and receives frames of either eight or nine data bits. Bit timing comes from an external tick running at sixteen times the bit rate. The receiver and the transmitter run independently of each other, so a frame can arrive while another is being sent.

In a nine-bit mode the ninth bit tells address frames (ninth bit 1) apart from data frames (ninth bit 0). When the multiprocessor filter is on, the receiver hands over only address frames that match the node. A frame matches when it equals the node's own address or the node's broadcast address. Bits cleared in a mask register are don't-care positions. When the filter is off, every nine-bit frame is delivered.

A stop bit sampled low sets a sticky framing-error flag. Software reads and writes that flag through the top bit of the control register while a view-select bit is set. While the select bit is clear, that same position holds a mode bit. Software works the block through a small register port and sees receive and transmit completion on two interrupt flags.

Top module: `mpuart`

## Requirements
- R1: After reset, all registers read 0x00, `txd` is 1 and both interrupt flags are 0. The register map is: 0 = control, 1 = data, 2 = own address, 3 = address mask, 4 = auxiliary (bit 0 is the error-view select). Control bits are: [7] mode bit A / error flag, [6] mode bit B, [5] filter enable, [4] receive enable, [3] transmit ninth bit, [2] received ninth bit, [1] transmit-done flag, [0] receive-done flag.
- R2: Mode {A,B} = 01 is the eight-bit mode. A frame is a start bit, eight data bits LSB first, then a stop bit. With receive enable set, a valid frame loads the byte into the data register, sets control bit 0 and `rx_irq`, and stores the stop bit in control bit 2. The filter enable has no effect in this mode. Software clears a flag by writing 0 to it.
- R3: Modes {A,B} = 10 and 11 are the nine-bit modes. A nine-bit frame is a start bit, eight data bits LSB first, the ninth bit, then a stop bit. With the filter off, every valid frame is delivered, and its ninth bit goes to control bit 2.
- R4: With the filter on in a nine-bit mode, an address frame (ninth bit 1) is delivered when ((byte XOR own) AND mask) is 0.
- R5: With the filter on in a nine-bit mode, a frame whose ninth bit is 0 is discarded. The receive flag stays 0 and the data register keeps its value.
- R6: With the filter on, an address frame whose byte has a 1 in every bit position that is 1 in (own OR mask) is also delivered (broadcast). Any other address frame is discarded.
- R7: A stop bit sampled as 0 sets the error flag and the frame is discarded. The flag stays set through later valid frames until software clears it.
- R8: While auxiliary bit 0 is 1, control bit 7 reads and writes the error flag and leaves mode bit A unchanged. While it is 0, control bit 7 reads and writes mode bit A.
- R9: A write to the data register in an active mode starts a frame on `txd`. In the nine-bit modes the ninth bit sent is control bit 3. At the end of the stop bit, control bit 1 and `tx_irq` are set.
- R10: A write to the data register while a frame is being sent is ignored.
- R11: The receiver samples each bit at ticks 7, 8 and 9 of 16 and keeps the majority value. A start bit that is not low by majority is dropped as noise.
- R12: In mode 00, the transmitter and the receiver stay idle and the filter enable has no effect.
- R13: A frame can be received while another is being transmitted, and both complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| reg_addr | input | 3 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| rx_irq | output | 1 | Receive-done flag |
| tx_irq | output | 1 | Transmit-done flag |

## Verification
Receive frames are driven in three groups. The first group is eight-bit frames, sent with the filter on and then off. The second is nine-bit frames with the filter off, with ninth bits 0 and 1. The third is filtered frames whose bytes hit the own address, hit only the broadcast address, hit neither, or carry a ninth bit of 0. Together these separate the mask test from the broadcast test and from the ninth-bit gate. A frame with a low stop bit, followed by a good frame, tells sticky error behaviour apart from error behaviour that clears itself. A short low pulse tells majority start-bit detection apart from edge-only detection. Transmit frames are decoded from the line, both alone and while a receive frame is in flight, to expose any coupling between the two directions.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
  localparam int unsigned DATA_W = 8;

  // mode code is {bit A, bit B}
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_8   = 2'b01,
    MODE_9A  = 2'b10,
    MODE_9B  = 2'b11
  } mode_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic is_nine(input mode_e m);
    return m == MODE_9A || m == MODE_9B;
  endfunction

  function automatic logic own_hit(input logic [DATA_W-1:0] byte_i,
                                   input logic [DATA_W-1:0] own,
                                   input logic [DATA_W-1:0] mask);
    return ((byte_i ^ own) & mask) == '0;
  endfunction

  function automatic logic bcast_hit(input logic [DATA_W-1:0] byte_i,
                                     input logic [DATA_W-1:0] own,
                                     input logic [DATA_W-1:0] mask);
    logic [DATA_W-1:0] b;
    b = own | mask;
    return (byte_i & b) == b;
  endfunction
endpackage

// File: rtl/mpuart_tx.sv
module mpuart_tx
  import mpuart_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic              nine,
  input  logic [DATA_W-1:0] data,
  input  logic              bit9,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned FW = DATA_W + 3;
  localparam int unsigned BW = $clog2(FW);

  logic [FW-1:0] frame_q;
  logic [BW-1:0] bidx_q, last_q;
  logic [CW-1:0] tcnt_q;
  logic          bit_end;

  assign bit_end = busy && tick && tcnt_q == CW'(OVS - 1);
  assign done    = bit_end && bidx_q == last_q;
  assign txd     = busy ? frame_q[bidx_q] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      frame_q <= '1;
      bidx_q  <= '0;
      last_q  <= '0;
      tcnt_q  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        frame_q <= {1'b1, (nine ? bit9 : 1'b1), data, 1'b0};
        last_q  <= nine ? BW'(DATA_W + 2) : BW'(DATA_W + 1);
        bidx_q  <= '0;
        tcnt_q  <= '0;
      end
    end else if (tick) begin
      if (tcnt_q == CW'(OVS - 1)) begin
        tcnt_q <= '0;
        if (bidx_q == last_q) busy <= 1'b0;
        else bidx_q <= bidx_q + 1'b1;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  // R9
  tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !txd);
  // R9
  tx_stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> txd);
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
  import mpuart_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd_s,
  input  logic              enable,
  input  mode_e             mode,
  input  logic              mp_en,
  input  logic [DATA_W-1:0] own,
  input  logic [DATA_W-1:0] mask,
  output logic              accept,
  output logic              ferr,
  output logic              addr_hit,
  output logic [DATA_W-1:0] data,
  output logic              bit9
);
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned MID = OVS / 2;
  localparam int unsigned BW  = $clog2(DATA_W + 3);

  logic          active_q, s_a_q, s_b_q, b9_q;
  logic [CW-1:0] tcnt_q;
  logic [BW-1:0] bidx_q, stop_idx;
  logic [DATA_W-1:0] sh_q;
  logic          dec, vote, frame_end, nine, filt;

  assign nine      = is_nine(mode);
  assign filt      = nine && mp_en;
  assign stop_idx  = nine ? BW'(DATA_W + 2) : BW'(DATA_W + 1);
  assign dec       = active_q && tick && tcnt_q == CW'(MID + 1);
  assign vote      = maj3(s_a_q, s_b_q, rxd_s);
  assign frame_end = dec && bidx_q == stop_idx;
  assign addr_hit  = frame_end && (own_hit(sh_q, own, mask) || bcast_hit(sh_q, own, mask));
  assign accept    = frame_end && vote && (!filt || (b9_q && addr_hit));
  assign ferr      = frame_end && !vote;
  assign data      = sh_q;
  assign bit9      = nine ? b9_q : vote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      tcnt_q   <= '0;
      bidx_q   <= '0;
      s_a_q    <= 1'b1;
      s_b_q    <= 1'b1;
      sh_q     <= '0;
      b9_q     <= 1'b0;
    end else if (!active_q) begin
      if (enable && tick && !rxd_s) begin
        active_q <= 1'b1;
        tcnt_q   <= CW'(1);
        bidx_q   <= '0;
      end
    end else if (tick) begin
      if (tcnt_q == CW'(MID - 1)) s_a_q <= rxd_s;
      if (tcnt_q == CW'(MID))     s_b_q <= rxd_s;
      if (dec) begin
        if (bidx_q == '0) begin
          if (vote) active_q <= 1'b0;
        end else if (bidx_q == stop_idx) begin
          active_q <= 1'b0;
        end else if (bidx_q <= BW'(DATA_W)) begin
          sh_q <= {vote, sh_q[DATA_W-1:1]};
        end else begin
          b9_q <= vote;
        end
      end
      if (tcnt_q == CW'(OVS - 1)) begin
        tcnt_q <= '0;
        bidx_q <= bidx_q + 1'b1;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  // R4
  rx_mp_bit9_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && filt) |-> (b9_q && addr_hit));
  // R7
  rx_ferr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ferr |=> !active_q);
endmodule

// File: rtl/mpuart.sv
module mpuart
  import mpuart_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        baud_tick,
  input  logic        rxd,
  output logic        txd,
  input  logic [2:0]  reg_addr,
  input  logic        reg_we,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        rx_irq,
  output logic        tx_irq
);
  localparam logic [2:0] A_CTRL = 3'd0, A_DATA = 3'd1, A_OWN = 3'd2,
                         A_MASK = 3'd3, A_AUX = 3'd4;

  logic m_a, m_b, mp_en, rx_en, tx9, rx9, tx_flag, rx_flag, fe_q, fe_view;
  logic [DATA_W-1:0] own_q, mask_q, rbuf_q;
  logic sync1_q, sync2_q;
  mode_e mode;
  logic ctrl_we, tx_start, tx_busy, tx_done;
  logic rx_accept, rx_ferr, rx_addr_hit, rx_bit9;
  logic [DATA_W-1:0] rx_data;

  assign mode     = mode_e'({m_a, m_b});
  assign ctrl_we  = reg_we && reg_addr == A_CTRL;
  assign tx_start = reg_we && reg_addr == A_DATA && mode != MODE_OFF;
  assign rx_irq   = rx_flag;
  assign tx_irq   = tx_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= rxd;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_a, m_b, mp_en, rx_en, tx9, rx9, tx_flag, rx_flag} <= '0;
      fe_q    <= 1'b0;
      fe_view <= 1'b0;
      own_q   <= '0;
      mask_q  <= '0;
      rbuf_q  <= '0;
    end else begin
      if (ctrl_we) begin
        if (fe_view) fe_q <= reg_wdata[7];
        else         m_a  <= reg_wdata[7];
        {m_b, mp_en, rx_en, tx9, rx9, tx_flag, rx_flag} <= reg_wdata[6:0];
      end
      if (reg_we && reg_addr == A_OWN)  own_q   <= reg_wdata;
      if (reg_we && reg_addr == A_MASK) mask_q  <= reg_wdata;
      if (reg_we && reg_addr == A_AUX)  fe_view <= reg_wdata[0];
      // hardware events take priority over a software write in the same cycle
      if (rx_ferr) fe_q <= 1'b1;
      if (rx_accept) begin
        rx_flag <= 1'b1;
        rbuf_q  <= rx_data;
        rx9     <= rx_bit9;
      end
      if (tx_done) tx_flag <= 1'b1;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = {(fe_view ? fe_q : m_a), m_b, mp_en, rx_en, tx9, rx9, tx_flag, rx_flag};
      A_DATA:  reg_rdata = rbuf_q;
      A_OWN:   reg_rdata = own_q;
      A_MASK:  reg_rdata = mask_q;
      A_AUX:   reg_rdata = {7'd0, fe_view};
      default: reg_rdata = 8'h00;
    endcase
  end

  mpuart_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .start(tx_start),
    .nine(is_nine(mode)), .data(reg_wdata), .bit9(tx9),
    .txd(txd), .busy(tx_busy), .done(tx_done)
  );

  mpuart_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd_s(sync2_q),
    .enable(rx_en && mode != MODE_OFF), .mode(mode), .mp_en(mp_en),
    .own(own_q), .mask(mask_q), .accept(rx_accept), .ferr(rx_ferr),
    .addr_hit(rx_addr_hit), .data(rx_data), .bit9(rx_bit9)
  );

  // R7
  fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_q && !(ctrl_we && fe_view)) |=> fe_q);
  // R12
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_DATA && mode == MODE_OFF && !tx_busy) |=> !tx_busy);
  // R5
  mp_data_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_accept && mp_en && is_nine(mode)) |-> rx_addr_hit);
endmodule

// File: tb/test_mpuart.sv
module test_mpuart;
  localparam int CLK_NS   = 10;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  typedef struct {
    logic [7:0] d;
    logic       b9;
    logic       nine;
  } item_t;

  logic clk = 0, rst_n = 0, baud_tick = 0, rxd = 1, reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic txd, rx_irq, tx_irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  item_t txq[$];
  item_t rxq[$];
  logic [7:0] last_data = 8'h00;
  logic [7:0] ctrl_sh = 8'h00;

  mpuart i_mpuart (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd), .txd(txd),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  always #(CLK_NS / 2) clk = ~clk;

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      baud_tick = (c % TICK_DIV) == 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_ctrl(input logic [7:0] v);
    ctrl_sh = v;
    wr(3'd0, v);
  endtask

  // driver: sends one frame on rxd, pushes the expected delivery
  task automatic send_rx(input logic [7:0] d, input logic nine, input logic b9,
                         input logic stop, input bit want);
    if (want) rxq.push_back('{d, (nine ? b9 : 1'b1), nine});
    @(negedge clk);
    rxd = 0; repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i]; repeat (BIT_CLKS) @(negedge clk);
    end
    if (nine) begin rxd = b9; repeat (BIT_CLKS) @(negedge clk); end
    rxd = stop; repeat (BIT_CLKS) @(negedge clk);
    rxd = 1; repeat (2 * BIT_CLKS) @(negedge clk);
  endtask

  // pops the expectation (if any) and compares against the register view
  task automatic rx_check(input string req);
    logic [7:0] d, c;
    rd(3'd1, d);
    rd(3'd0, c);
    if (rxq.size() != 0) begin
      item_t e = rxq.pop_front();
      chk(rx_irq === 1'b1, req, rx_irq, 1);
      chk(d === e.d, req, d, e.d);
      chk(c[2] === e.b9, req, c[2], e.b9);
      last_data = e.d;
      set_ctrl(ctrl_sh);
    end else begin
      chk(rx_irq === 1'b0, req, rx_irq, 0);
      chk(d === last_data, req, d, last_data);
    end
  endtask

  // monitor: decodes txd and compares with the queue
  initial begin
    logic [7:0] d;
    logic b9, st, sp;
    item_t e;
    bit have;
    forever begin
      @(negedge txd);
      have = txq.size() != 0;
      if (have) e = txq.pop_front();
      else e = '{8'h00, 1'b1, 1'b1};
      repeat (BIT_CLKS / 2) @(negedge clk);
      st = txd;
      for (int i = 0; i < 8; i++) begin
        repeat (BIT_CLKS) @(negedge clk);
        d[i] = txd;
      end
      b9 = 1'b1;
      if (e.nine) begin repeat (BIT_CLKS) @(negedge clk); b9 = txd; end
      repeat (BIT_CLKS) @(negedge clk);
      sp = txd;
      chk(have, "R10 unexpected tx frame", d, 0);
      chk(st === 1'b0, "R9 start", st, 0);
      chk(d === e.d, "R9 data", d, e.d);
      chk(b9 === e.b9, "R9 ninth", b9, e.b9);
      chk(sp === 1'b1, "R9 stop", sp, 1);
    end
  end

  task automatic tx_wait_done(input string req);
    repeat (12 * BIT_CLKS) @(negedge clk);
    chk(tx_irq === 1'b1, req, tx_irq, 1);
    chk(txq.size() == 0, req, txq.size(), 0);
    set_ctrl(ctrl_sh);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk(v === 8'h00, "R1 register reset", v, 0);
    end
    chk(txd === 1'b1 && rx_irq === 1'b0 && tx_irq === 1'b0, "R1 outputs", {txd, rx_irq, tx_irq}, 3'b100);

    // R2 eight-bit mode, filter enabled but without effect
    set_ctrl(8'h70);
    send_rx(8'hA5, 0, 0, 1, 1);
    rx_check("R2 eight-bit receive");
    send_rx(8'h7A, 0, 0, 1, 1);
    rx_check("R2 eight-bit filter ignored");

    // R3 nine-bit mode, no filter
    set_ctrl(8'h90);
    send_rx(8'h3C, 1, 0, 1, 1);
    rx_check("R3 ninth bit 0");
    send_rx(8'hC3, 1, 1, 1, 1);
    rx_check("R3 ninth bit 1");

    // R4 R5 R6 filtered reception
    wr(3'd2, 8'h35);
    wr(3'd3, 8'hF0);
    rd(3'd2, v); chk(v === 8'h35, "R1 own address write", v, 8'h35);
    set_ctrl(8'hB0);
    send_rx(8'h3A, 1, 1, 1, 1);
    rx_check("R4 own address match");
    send_rx(8'h3A, 1, 0, 1, 0);
    rx_check("R5 data frame dropped");
    send_rx(8'h7A, 1, 1, 1, 0);
    rx_check("R6 no match dropped");
    send_rx(8'hFF, 1, 1, 1, 1);
    rx_check("R6 broadcast match");

    // R7 R8 framing error
    set_ctrl(8'h90);
    send_rx(8'h11, 1, 0, 0, 0);
    rx_check("R7 bad stop dropped");
    wr(3'd4, 8'h01);
    rd(3'd0, v); chk(v[7] === 1'b1, "R7 error flag set", v[7], 1);
    wr(3'd4, 8'h00);
    rd(3'd0, v); chk(v[7] === 1'b1 && v[6] === 1'b0, "R8 mode bit view", v[7:6], 2'b10);
    send_rx(8'h22, 1, 1, 1, 1);
    rx_check("R7 good frame after error");
    wr(3'd4, 8'h01);
    rd(3'd0, v); chk(v[7] === 1'b1, "R7 error flag sticky", v[7], 1);
    wr(3'd0, 8'h10);
    rd(3'd0, v); chk(v[7] === 1'b0, "R8 error cleared via alias", v[7], 0);
    wr(3'd4, 8'h00);
    rd(3'd0, v); chk(v[7] === 1'b1, "R8 mode bit kept", v[7], 1);

    // R11 short low pulse is noise
    @(negedge clk); rxd = 0;
    repeat (3 * TICK_DIV) @(negedge clk); rxd = 1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    rx_check("R11 glitch ignored");
    send_rx(8'h5A, 1, 0, 1, 1);
    rx_check("R11 frame after glitch");

    // R9 transmit, nine-bit with ninth bit 1, then eight-bit
    set_ctrl(8'h98);
    txq.push_back('{8'hC9, 1'b1, 1'b1});
    wr(3'd1, 8'hC9);
    tx_wait_done("R9 nine-bit transmit done");
    set_ctrl(8'h50);
    txq.push_back('{8'h4E, 1'b1, 1'b0});
    wr(3'd1, 8'h4E);
    tx_wait_done("R9 eight-bit transmit done");

    // R10 write while busy ignored
    txq.push_back('{8'h11, 1'b1, 1'b0});
    wr(3'd1, 8'h11);
    repeat (50) @(negedge clk);
    wr(3'd1, 8'h22);
    tx_wait_done("R10 busy write ignored");
    repeat (12 * BIT_CLKS) @(negedge clk);
    chk(tx_irq === 1'b0, "R10 no second frame", tx_irq, 0);

    // R13 full duplex
    set_ctrl(8'h90);
    txq.push_back('{8'h3C, 1'b0, 1'b1});
    fork
      send_rx(8'h96, 1, 1, 1, 1);
      begin
        repeat (3 * BIT_CLKS) @(negedge clk);
        wr(3'd1, 8'h3C);
      end
    join
    rx_check("R13 receive during transmit");
    tx_wait_done("R13 transmit during receive");

    // R12 mode 00: nothing moves, filter ignored
    set_ctrl(8'h30);
    wr(3'd1, 8'h81);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT_CLKS) @(negedge clk);
      chk(txd === 1'b1, "R12 txd idle", txd, 1);
    end
    send_rx(8'h35, 1, 1, 1, 0);
    rx_check("R12 receiver idle");
    repeat (4 * BIT_CLKS) @(negedge clk);
    chk(tx_irq === 1'b0, "R12 no transmit flag", tx_irq, 0);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule